// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits between a simple request port and a four-bank double-data-rate SDRAM. It takes one request at a time, each with a bank, a row, a column, a direction and an optional auto-precharge flag. It turns the request into the command stream the memory expects. For each bank it records whether a row is open and which row that is. A request to the open row goes straight to the column command. A request to a closed bank first opens the row with ACTIVE. A request to a bank holding a different row first closes that row with PRECHARGE, then opens the new row. Every spacing between commands comes from a parameter counted in clock cycles.

A free-running timer, sized from the clock frequency and the 7.8 µs refresh period, marks a refresh as due. A due refresh takes priority over user traffic. If any bank is open, the block first closes all banks with one precharge-all command, then issues AUTO REFRESH. The block also has a read-capture window output. This output goes high for the cycles in which read data is due, based on the CAS latency and the burst length.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the memory side shows a NOP, `req_ready` is high and `rd_window` is low.
- R2: A request to a closed bank produces ACTIVE with the bank on `mem_ba` and the row on `mem_addr` in the cycle of acceptance. READ (request with `req_write`=0) or WRITE follows exactly T_RCD cycles later. The column is placed on address bits 9:0 and the auto-precharge flag on bit 10.
- R3: A request to the row already open in its bank produces its READ or WRITE in the cycle of acceptance, with no ACTIVE or PRECHARGE before it.
- R4: A request to a bank holding a different row produces PRECHARGE to that bank with bit 10 low in the cycle of acceptance. ACTIVE follows T_RP cycles later and the column command T_RCD cycles after the ACTIVE.
- R5: A column command with bit 10 set closes its bank. The next request to that bank is accepted no earlier than BURST_LEN/2 + T_RP cycles after the column command, and it starts with ACTIVE.
- R6: Two back-to-back row-hit requests give column commands exactly BURST_LEN/2 cycles apart.
- R7: A refresh becomes due every CLK_MHZ*REF_NS/1000 cycles (1950 by default), counted from reset, and is served in the next cycle if the block is idle. If any bank is open, a precharge-all (PRECHARGE, bit 10 high, bank 0) comes first, with AUTO REFRESH T_RP cycles later. If all banks are closed, AUTO REFRESH is issued directly.
- R8: While a refresh is due, `req_ready` is low. A waiting request is accepted only T_RFC cycles after the AUTO REFRESH.
- R9: After READ, `rd_window` is high for BURST_LEN/2 cycles, starting ceil(CL_X2/2) cycles after the READ. WRITE does not raise it.
- R10: Each command lasts one cycle. Every other cycle carries NOP. Encodings as {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001. Chip select stays low.
- R11: A bank's open row survives activity in other banks, so a later request to it is still a row hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands launch on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row at the end of the burst |
| req_bank | input | BANK_W (2) | Target bank |
| req_row | input | ROW_W (13) | Target row |
| req_col | input | COL_W (10) | Starting column |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BANK_W (2) | Bank address |
| mem_addr | output | ROW_W (13) | Row / column address, bit 10 = auto precharge |
| rd_window | output | 1 | High while read data is due |

## Verification
The bench goes after the three row outcomes: hit, closed bank and conflict. A design that mixed them up would send a column command to a closed or wrong row, or waste a precharge and activate on a hit. It measures exact command spacing for T_RCD, T_RP, burst-to-burst and auto-precharge recovery, where an off-by-one counter would shift a command by a cycle. It checks the refresh path with banks open and with banks closed, where a design would otherwise refresh over an open row or insert a needless precharge. It holds a request during a due refresh to catch a design that lets user traffic jump ahead. It also places the read window against the CAS latency, so that a wrong rounding of the half-cycle latency shows up.

// File: rtl/ddr_seq_pkg.sv
// Package: command encodings and sequencer states shared by the
// command sequencer and its submodules.
package ddr_seq_pkg;

    // Command encoding as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001
    } ddr_cmd_e;

    // Sequencer state: which command is next once the wait counter drains
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_COL  = 2'd2,
        ST_REF  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/ddr_bank_table.sv
// Per-bank open-row table.
// Records, for each bank, whether a row is open and which one.
// Assumes at most one event per cycle; ACTIVE has priority over close.
module ddr_bank_table #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             act_en,
    input  logic                             close_one,
    input  logic                             close_all,
    input  logic [BANK_W-1:0]                bank_sel,
    input  logic [ROW_W-1:0]                 act_row,
    output logic [NUM_BANKS-1:0]             bank_open,
    output logic [NUM_BANKS-1:0][ROW_W-1:0]  open_row
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit_sel;
        assign hit_sel = (bank_sel == BANK_W'(b));

        // Update the open flag and row of one bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_open[b] <= 1'b0;
                open_row[b]  <= '0;
            end else if (act_en && hit_sel) begin
                bank_open[b] <= 1'b1;
                open_row[b]  <= act_row;
            end else if (close_all || (close_one && hit_sel)) begin
                bank_open[b] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ddr_refresh_timer.sv
// Refresh timer.
// Free-running counter of INTERVAL cycles; raises ref_pending on each
// wrap and holds it until the sequencer reports the refresh issued.
// Assumes INTERVAL >= 2.
module ddr_refresh_timer #(
    parameter int INTERVAL = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_done,
    output logic ref_pending
);

    localparam int CW = $clog2(INTERVAL);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(INTERVAL - 1));

    // Count the interval and wrap
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // Hold a due refresh until it is served; a new wrap wins
    always_ff @(posedge clk) begin
        if (!rst_n)        ref_pending <= 1'b0;
        else if (wrap)     ref_pending <= 1'b1;
        else if (ref_done) ref_pending <= 1'b0;
    end

endmodule

// File: rtl/ddr_read_window.sv
// Read-capture window.
// Delays each READ by CL_CYC cycles, then holds rd_window high for
// BURST_CYC cycles. Assumes READs are at least BURST_CYC cycles apart.
module ddr_read_window #(
    parameter int CL_CYC    = 3,
    parameter int BURST_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_issue,
    output logic rd_window
);

    localparam int BW = $clog2(BURST_CYC) + 1;

    logic [CL_CYC-1:0] pipe;
    logic [BW-1:0]     bcnt;
    logic              start;

    if (CL_CYC == 1) begin : g_short
        // Single-stage latency delay
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= rd_issue;
        end
    end else begin : g_long
        // Multi-stage latency delay line
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[CL_CYC-2:0], rd_issue};
        end
    end

    assign start = pipe[CL_CYC-1];

    // Open the window on a delayed READ and close it after the burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_window <= 1'b0;
            bcnt      <= '0;
        end else if (start) begin
            rd_window <= 1'b1;
            bcnt      <= BW'(BURST_CYC - 1);
        end else if (rd_window) begin
            if (bcnt == '0) rd_window <= 1'b0;
            else            bcnt      <= bcnt - 1'b1;
        end
    end

endmodule

// File: rtl/ddr_cmd_seq.sv
// DDR SDRAM command sequencer (top).
// Serves one request at a time: row hit -> column command; closed bank ->
// ACTIVE then column; row conflict -> PRECHARGE, ACTIVE, column. A due
// refresh wins over requests and closes open banks first. All outputs
// are registered. Assumes COL_W <= ROW_W-1 (address bit 10 carries the
// auto-precharge flag) and all timing parameters >= 1.
module ddr_cmd_seq #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int BURST_LEN = 8,
    parameter int CL_X2     = 5,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 14,
    parameter int CLK_MHZ   = 250,
    parameter int REF_NS    = 7800,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_autopre,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BANK_W-1:0] mem_ba,
    output logic [ROW_W-1:0]  mem_addr,
    output logic              rd_window
);

    import ddr_seq_pkg::*;

    localparam int BURST_CYC  = BURST_LEN / 2;
    localparam int CL_CYC     = (CL_X2 + 1) / 2;
    localparam int REF_CYCLES = CLK_MHZ * REF_NS / 1000;
    localparam int AP_BIT     = 10;
    localparam int CX_W       = ROW_W - 1;
    localparam int W_A        = (T_RFC > T_RP + BURST_CYC) ? T_RFC : T_RP + BURST_CYC;
    localparam int WAIT_MAX   = (W_A > T_RCD) ? W_A : T_RCD;
    localparam int WAIT_W     = $clog2(WAIT_MAX + 1);

    seq_state_e                     state, nxt_state;
    ddr_cmd_e                       cmd_q, nxt_cmd;
    logic [BANK_W-1:0]              ba_q, nxt_ba;
    logic [ROW_W-1:0]               addr_q, nxt_addr;
    logic [WAIT_W-1:0]              wait_cnt, nxt_wait;
    logic                           wait_done;
    logic                           accept, ref_taken, ref_pending;
    logic                           row_hit;
    logic [NUM_BANKS-1:0]           bank_open;
    logic [NUM_BANKS-1:0][ROW_W-1:0] open_row;
    logic                           lat_write, lat_ap;
    logic [BANK_W-1:0]              lat_bank;
    logic [ROW_W-1:0]               lat_row;
    logic [COL_W-1:0]               lat_col;
    logic                           is_col, col_ap;

    // Place a column on the address bus around the auto-precharge bit
    function automatic logic [ROW_W-1:0] col_addr(input logic [COL_W-1:0] c,
                                                  input logic ap);
        logic [ROW_W-1:0] a;
        logic [CX_W-1:0]  cx;
        cx = CX_W'(c);
        a  = '0;
        for (int i = 0; i < ROW_W; i++) begin
            if (i < AP_BIT)      a[i] = cx[i];
            else if (i > AP_BIT) a[i] = cx[i-1];
            else                 a[i] = ap;
        end
        return a;
    endfunction

    // Wait after a column command: burst, plus row close when auto precharging
    function automatic logic [WAIT_W-1:0] col_wait(input logic ap);
        return ap ? WAIT_W'(BURST_CYC + T_RP - 1) : WAIT_W'(BURST_CYC - 1);
    endfunction

    assign wait_done = (wait_cnt == '0);
    assign row_hit   = bank_open[req_bank] && (open_row[req_bank] == req_row);
    assign req_ready = (state == ST_IDLE) && wait_done && !ref_pending;

    // Choose the next command, state and wait from the current state
    always_comb begin
        nxt_cmd   = CMD_NOP;
        nxt_ba    = '0;
        nxt_addr  = '0;
        nxt_state = state;
        nxt_wait  = wait_done ? '0 : wait_cnt - 1'b1;
        accept    = 1'b0;
        ref_taken = 1'b0;
        case (state)
            ST_IDLE: begin
                if (wait_done && ref_pending) begin
                    if (|bank_open) begin
                        nxt_cmd          = CMD_PRE;
                        nxt_addr[AP_BIT] = 1'b1;
                        nxt_state        = ST_REF;
                        nxt_wait         = WAIT_W'(T_RP - 1);
                    end else begin
                        nxt_cmd   = CMD_REF;
                        ref_taken = 1'b1;
                        nxt_wait  = WAIT_W'(T_RFC - 1);
                    end
                end else if (wait_done && req_valid) begin
                    accept = 1'b1;
                    nxt_ba = req_bank;
                    if (row_hit) begin
                        nxt_cmd  = req_write ? CMD_WR : CMD_RD;
                        nxt_addr = col_addr(req_col, req_autopre);
                        nxt_wait = col_wait(req_autopre);
                    end else if (bank_open[req_bank]) begin
                        nxt_cmd   = CMD_PRE;
                        nxt_state = ST_ACT;
                        nxt_wait  = WAIT_W'(T_RP - 1);
                    end else begin
                        nxt_cmd   = CMD_ACT;
                        nxt_addr  = req_row;
                        nxt_state = ST_COL;
                        nxt_wait  = WAIT_W'(T_RCD - 1);
                    end
                end
            end
            ST_ACT: begin
                if (wait_done) begin
                    nxt_cmd   = CMD_ACT;
                    nxt_ba    = lat_bank;
                    nxt_addr  = lat_row;
                    nxt_state = ST_COL;
                    nxt_wait  = WAIT_W'(T_RCD - 1);
                end
            end
            ST_COL: begin
                if (wait_done) begin
                    nxt_cmd   = lat_write ? CMD_WR : CMD_RD;
                    nxt_ba    = lat_bank;
                    nxt_addr  = col_addr(lat_col, lat_ap);
                    nxt_state = ST_IDLE;
                    nxt_wait  = col_wait(lat_ap);
                end
            end
            default: begin
                if (wait_done) begin
                    nxt_cmd   = CMD_REF;
                    ref_taken = 1'b1;
                    nxt_state = ST_IDLE;
                    nxt_wait  = WAIT_W'(T_RFC - 1);
                end
            end
        endcase
    end

    // Register the command bus, state and wait counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            cmd_q    <= CMD_NOP;
            ba_q     <= '0;
            addr_q   <= '0;
        end else begin
            state    <= nxt_state;
            wait_cnt <= nxt_wait;
            cmd_q    <= nxt_cmd;
            ba_q     <= nxt_ba;
            addr_q   <= nxt_addr;
        end
    end

    // Capture the accepted request for the later steps of its sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_ap    <= 1'b0;
            lat_bank  <= '0;
            lat_row   <= '0;
            lat_col   <= '0;
        end else if (accept) begin
            lat_write <= req_write;
            lat_ap    <= req_autopre;
            lat_bank  <= req_bank;
            lat_row   <= req_row;
            lat_col   <= req_col;
        end
    end

    assign is_col = (nxt_cmd == CMD_RD) || (nxt_cmd == CMD_WR);
    assign col_ap = is_col && nxt_addr[AP_BIT];

    ddr_bank_table #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .BANK_W    (BANK_W)
    ) u_bank_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_en    (nxt_cmd == CMD_ACT),
        .close_one (((nxt_cmd == CMD_PRE) && !nxt_addr[AP_BIT]) || col_ap),
        .close_all ((nxt_cmd == CMD_PRE) && nxt_addr[AP_BIT]),
        .bank_sel  (nxt_ba),
        .act_row   (nxt_addr),
        .bank_open (bank_open),
        .open_row  (open_row)
    );

    ddr_refresh_timer #(
        .INTERVAL (REF_CYCLES)
    ) u_refresh_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_done    (ref_taken),
        .ref_pending (ref_pending)
    );

    ddr_read_window #(
        .CL_CYC    (CL_CYC),
        .BURST_CYC (BURST_CYC)
    ) u_read_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_issue  (nxt_cmd == CMD_RD),
        .rd_window (rd_window)
    );

    assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
    assign mem_ba   = ba_q;
    assign mem_addr = addr_q;

endmodule

// File: rtl/ddr_cmd_seq_checker.sv
// Protocol checker for the command sequencer.
// Rebuilds bank state from the memory-side pins alone and checks command
// legality and minimum spacings with saturating gap counters.
module ddr_cmd_seq_checker #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_cs_n,
    input logic              mem_ras_n,
    input logic              mem_cas_n,
    input logic              mem_we_n,
    input logic [BANK_W-1:0] mem_ba,
    input logic [ROW_W-1:0]  mem_addr
);

    logic [3:0]           pins;
    logic                 is_act, is_col, is_pre, is_ref;
    logic [NUM_BANKS-1:0] open_m;
    logic [7:0]           act_gap, pre_gap;

    assign pins   = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    assign is_act = (pins == 4'b0011);
    assign is_col = (pins == 4'b0101) || (pins == 4'b0100);
    assign is_pre = (pins == 4'b0010);
    assign is_ref = (pins == 4'b0001);

    // Track open banks as seen on the pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_m <= '0;
        end else if (is_act) begin
            open_m[mem_ba] <= 1'b1;
        end else if (is_pre && mem_addr[10]) begin
            open_m <= '0;
        end else if (is_pre || (is_col && mem_addr[10])) begin
            open_m[mem_ba] <= 1'b0;
        end
    end

    // Cycles since the last ACTIVE and the last PRECHARGE, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_gap <= 8'hFF;
            pre_gap <= 8'hFF;
        end else begin
            act_gap <= is_act ? 8'd1 : (act_gap == 8'hFF ? act_gap : act_gap + 8'd1);
            pre_gap <= is_pre ? 8'd1 : (pre_gap == 8'hFF ? pre_gap : pre_gap + 8'd1);
        end
    end

    AST_CS_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n == 1'b0);                                          // R10
    AST_COL_OPEN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> open_m[mem_ba]);                                 // R2
    AST_ACT_CLOSED_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> !open_m[mem_ba]);                                // R4
    AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (open_m == '0));                                 // R7
    AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (act_gap >= 8'(T_RCD)));                         // R2
    AST_RP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act || is_ref) |-> (pre_gap >= 8'(T_RP)));              // R4

endmodule

bind ddr_cmd_seq ddr_cmd_seq_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .T_RCD     (T_RCD),
    .T_RP      (T_RP),
    .BANK_W    (BANK_W)
) u_ddr_cmd_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_cs_n  (mem_cs_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_ba    (mem_ba),
    .mem_addr  (mem_addr)
);

// File: tb/ddr_cmd_seq_bench.sv
`timescale 1ns/1ps
// Directed bench for the command sequencer, default parameters.
module ddr_cmd_seq_bench;

    localparam int  BC     = 4;     // BURST_LEN/2
    localparam int  CL     = 3;     // ceil(2.5)
    localparam int  TRCD   = 3;
    localparam int  TRP    = 3;
    localparam int  TRFC   = 14;
    localparam int  NREF   = 1950;  // 250 MHz * 7.8 us
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_ready, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, rd_window;
    logic [1:0]  mem_ba;
    logic [12:0] mem_addr;

    int checks = 0, failures = 0, cycle = 0, log_n = 0;
    int          log_cyc  [0:63];
    logic [3:0]  log_cmd  [0:63];
    logic [1:0]  log_ba   [0:63];
    logic [12:0] log_addr [0:63];
    logic        win_hist [0:1023];

    always #2 clk = ~clk;

    ddr_cmd_seq u_ddr_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_autopre(req_autopre), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .mem_cs_n(mem_cs_n),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_ba(mem_ba), .mem_addr(mem_addr), .rd_window(rd_window));

    wire [3:0] pins = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

    always @(posedge clk) if (rst_n) cycle = cycle + 1;

    // Log every non-NOP command and the read window, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cycle < 1024) win_hist[cycle] = rd_window;
            if (pins != C_NOP && log_n < 64) begin
                log_cyc[log_n] = cycle; log_cmd[log_n] = pins;
                log_ba[log_n] = mem_ba; log_addr[log_n] = mem_addr;
                log_n = log_n + 1;
            end
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_cmd(input int idx, input logic [3:0] c, input int cyc,
                              input int ba, input int addr, input string req);
        checks++;
        if (idx >= log_n) begin
            failures++;
            $display("FAIL %s: command #%0d missing, actual count=%0d expected>%0d", req, idx, log_n, idx);
        end else if (log_cmd[idx] != c || log_cyc[idx] != cyc ||
                     int'(log_ba[idx]) != ba || int'(log_addr[idx]) != addr) begin
            failures++;
            $display("FAIL %s: actual cmd=%b cyc=%0d ba=%0d addr=%h expected cmd=%b cyc=%0d ba=%0d addr=%h",
                     req, log_cmd[idx], log_cyc[idx], log_ba[idx], log_addr[idx], c, cyc, ba, addr);
        end
    endtask

    // Present one request at a negedge; return the accepting edge's cycle
    task automatic do_req(input logic wr, input logic ap, input int bank, input int row,
                          input int col, output int acc);
        req_valid = 1'b1; req_write = wr; req_autopre = ap;
        req_bank = 2'(bank); req_row = 13'(row); req_col = 10'(col);
        while (!req_ready) @(negedge clk);
        acc = cycle + 1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check_eq("R1", "pins", int'(pins), int'(C_NOP));
        check_eq("R1", "req_ready", int'(req_ready), 1);
        check_eq("R1", "rd_window", int'(rd_window), 0);
    endtask

    task automatic t_closed_read;
        int a, m;
        m = log_n;
        do_req(1'b0, 1'b0, 0, 'h123, 'h045, a);
        idle(12);
        expect_cmd(m,   C_ACT, a,        0, 'h123, "R2");
        expect_cmd(m+1, C_RD,  a + TRCD, 0, 'h045, "R2");
        check_eq("R9", "window before", int'(win_hist[a+TRCD+CL-1]), 0);
        check_eq("R9", "window first",  int'(win_hist[a+TRCD+CL]), 1);
        check_eq("R9", "window last",   int'(win_hist[a+TRCD+CL+BC-1]), 1);
        check_eq("R9", "window after",  int'(win_hist[a+TRCD+CL+BC]), 0);
    endtask

    task automatic t_hit_pair;
        int a1, a2, m, seen;
        m = log_n;
        do_req(1'b1, 1'b0, 0, 'h123, 'h010, a1);
        do_req(1'b1, 1'b0, 0, 'h123, 'h018, a2);
        idle(10);
        check_eq("R3", "commands logged", log_n - m, 2);
        expect_cmd(m,   C_WR, a1,      0, 'h010, "R3");
        expect_cmd(m+1, C_WR, a1 + BC, 0, 'h018, "R6");
        seen = 0;
        for (int i = a1; i < a1 + 12; i++) seen = seen | int'(win_hist[i]);
        check_eq("R9", "window on writes", seen, 0);
    endtask

    task automatic t_miss;
        int a, m;
        m = log_n;
        do_req(1'b0, 1'b0, 0, 'h0AA, 'h005, a);
        idle(14);
        expect_cmd(m,   C_PRE, a,              0, 0,     "R4");
        expect_cmd(m+1, C_ACT, a + TRP,        0, 'h0AA, "R4");
        expect_cmd(m+2, C_RD,  a + TRP + TRCD, 0, 'h005, "R4");
    endtask

    task automatic t_bank_indep;
        int a, b, m;
        m = log_n;
        do_req(1'b0, 1'b0, 2, 'h300, 'h001, a);
        do_req(1'b0, 1'b0, 0, 'h0AA, 'h002, b);
        idle(10);
        expect_cmd(m,   C_ACT, a,        2, 'h300, "R11");
        expect_cmd(m+1, C_RD,  a + TRCD, 2, 'h001, "R11");
        expect_cmd(m+2, C_RD,  b,        0, 'h002, "R11");
        check_eq("R11", "commands logged", log_n - m, 3);
    endtask

    task automatic t_autopre;
        int a, b, m;
        m = log_n;
        do_req(1'b1, 1'b1, 1, 'h055, 'h007, a);
        do_req(1'b0, 1'b0, 1, 'h055, 'h008, b);
        idle(10);
        expect_cmd(m,   C_ACT, a,        1, 'h055, "R5");
        expect_cmd(m+1, C_WR,  a + TRCD, 1, 'h407, "R2");
        check_eq("R5", "reaccept cycle", b, a + TRCD + BC + TRP);
        expect_cmd(m+2, C_ACT, b,        1, 'h055, "R5");
        expect_cmd(m+3, C_RD,  b + TRCD, 1, 'h008, "R5");
    endtask

    task automatic t_refresh;
        int m;
        m = log_n;
        while (cycle < NREF + TRP + 4) @(negedge clk);
        expect_cmd(m,   C_PRE, NREF + 1,       0, 'h400, "R7");
        expect_cmd(m+1, C_REF, NREF + 1 + TRP, 0, 0,     "R7");
        m = log_n;
        while (cycle < 2*NREF + 4) @(negedge clk);
        expect_cmd(m, C_REF, 2*NREF + 1, 0, 0, "R7");
        check_eq("R7", "commands logged", log_n - m, 1);
    endtask

    task automatic t_ref_priority;
        int a, m;
        while (cycle < 3*NREF) @(negedge clk);
        m = log_n;
        check_eq("R8", "req_ready while due", int'(req_ready), 0);
        do_req(1'b0, 1'b0, 3, 'h001, 'h000, a);
        idle(8);
        expect_cmd(m,   C_REF, 3*NREF + 1,        0, 0, "R8");
        expect_cmd(m+1, C_ACT, 3*NREF + 1 + TRFC, 3, 1, "R8");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_closed_read;
        t_hit_pair;
        t_miss;
        t_bank_indep;
        t_autopre;
        t_refresh;
        t_ref_priority;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule